// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Flags

This block is the receive-side store of a UART-style serial port. The deserialiser presents one byte per frame tick on a write port. The block holds up to 16 bytes in arrival order, and the CPU drains them through a read port. A programmable trigger level sets the fill at which the queue reports that it is full enough to service.

Status outputs give the current fill count, a receive-data-full flag, a data-ready flag and a sticky overrun bit. The data-ready flag covers a partial queue that has stopped filling: it rises after two frame ticks in a row with no new byte. Two interrupt requests are driven, one for receive and one for error. A flush input empties the queue. A read issued with a clear request drops the receive flags once the fill has fallen below the trigger.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue stores up to 16 bytes and returns them in arrival order. `fill_count` (5 bits) gives the number of bytes held and never exceeds 16.
- R2: `level_sel` picks the trigger level: 0 selects 1 byte, 1 selects 4, 2 selects 8 and 3 selects 14.
- R3: A byte that arrives while the queue holds 16 bytes and no read is taking place is discarded. The byte leaves `fill_count` unchanged and sets `overrun` one cycle later. It also sets `err_irq` if `rxi_en` or `eri_en` is high. A pulse on `ovr_clr` clears both `overrun` and `err_irq`.
- R4: After an accepted byte brings the count to the trigger level or above, `data_full` is set on the next cycle. `rx_irq` is set at the same time if `rxi_en` is high.
- R5: On a frame tick with no accepted byte, `data_ready` is set if three conditions hold: the previous frame tick also accepted no byte, the queue is not empty, and the count is below the trigger. `rx_irq` is raised with it if `rxi_en` is high.
- R6: A byte is accepted only when `frame_tick`, `byte_valid` and `rx_enable` are all high and `overrun` is low. Any other byte leaves `fill_count` unchanged.
- R7: `q_flush` zeroes the count and clears `data_full`, `data_ready` and `rx_irq` on the next cycle. It does not clear `overrun`.
- R8: A read with `rd_clr` high clears `data_full` and `data_ready` only if the remaining count is below the trigger. `rx_irq` is only high while at least one of those two flags is set.
- R9: A read of an empty queue presents zero on `rd_data` and leaves the count and all flags unchanged.
- R10: When a byte arrives and a read happens in the same cycle on a full queue, the byte is accepted, the count stays at 16 and no overrun is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| q_flush | input | 1 | Empties the queue and clears the receive flags |
| rx_enable | input | 1 | Reception enable |
| rxi_en | input | 1 | Receive interrupt enable |
| eri_en | input | 1 | Error interrupt enable |
| level_sel | input | 2 | Trigger level select |
| frame_tick | input | 1 | One pulse per serial frame time |
| byte_valid | input | 1 | A byte is present on `byte_in` this frame |
| byte_in | input | 8 | Received byte |
| rd_req | input | 1 | CPU read of the oldest byte |
| rd_clr | input | 1 | Flag clear request accompanying a read |
| ovr_clr | input | 1 | Clears the overrun bit and error interrupt |
| rd_data | output | 8 | Oldest byte, or zero when empty |
| fill_count | output | 5 | Bytes currently held |
| data_full | output | 1 | Receive-data-full flag |
| data_ready | output | 1 | Data-ready (idle line) flag |
| overrun | output | 1 | Sticky overrun bit |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Several behaviours are checked by assertions on every cycle: the count bound, the dropped byte that leaves the count unchanged and sets overrun, the rule that a receive interrupt needs a flag, gated arrivals, flush, empty reads and the full-queue swap. Only the bench scenarios can show byte ordering through the queue, the exact tick on which data-ready rises after two idle frames, and each of the four trigger levels. They also cover clear-on-read, which depends on where the count stands relative to the trigger, and the masking of interrupts by the enables.

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         q_flush,
  input  logic                         rx_enable,
  input  logic                         rxi_en,
  input  logic                         eri_en,
  input  logic [1:0]                   level_sel,
  input  logic                         frame_tick,
  input  logic                         byte_valid,
  input  logic [DW-1:0]                byte_in,
  input  logic                         rd_req,
  input  logic                         rd_clr,
  input  logic                         ovr_clr,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(DEPTH):0]       fill_count,
  output logic                         data_full,
  output logic                         data_ready,
  output logic                         overrun,
  output logic                         rx_irq,
  output logic                         err_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          rcvd_last;

  logic [CW-1:0] trig;
  always_comb begin
    case (level_sel)
      2'd0:    trig = CW'(TRIG_0);
      2'd1:    trig = CW'(TRIG_1);
      2'd2:    trig = CW'(TRIG_2);
      default: trig = CW'(TRIG_3);
    endcase
  end

  wire empty  = (fill_count == '0);
  wire full   = (fill_count == CW'(DEPTH));
  wire pop    = rd_req && !empty;
  wire arrive = frame_tick && byte_valid && rx_enable && !overrun;
  wire push   = arrive && (!full || pop);
  wire drop   = arrive && full && !pop;

  wire [CW-1:0] cnt_nx   = fill_count + CW'(push) - CW'(pop);
  wire          rdf_set  = push && (cnt_nx >= trig);
  wire          flag_clr = pop && rd_clr && (cnt_nx < trig);
  wire          dr_set   = frame_tick && !push && !rcvd_last && !data_ready &&
                           (cnt_nx != '0) && (cnt_nx < trig);
  wire          rdf_nx   = (data_full && !flag_clr) || rdf_set;
  wire          dr_nx    = (data_ready && !flag_clr) || dr_set;

  assign rd_data = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push && !q_flush) mem[wp] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      rp         <= '0;
      fill_count <= '0;
      data_full  <= 1'b0;
      data_ready <= 1'b0;
      rx_irq     <= 1'b0;
      rcvd_last  <= 1'b0;
    end else if (q_flush) begin
      wp         <= '0;
      rp         <= '0;
      fill_count <= '0;
      data_full  <= 1'b0;
      data_ready <= 1'b0;
      rx_irq     <= 1'b0;
      rcvd_last  <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      fill_count <= cnt_nx;
      data_full  <= rdf_nx;
      data_ready <= dr_nx;
      if (!(rdf_nx || dr_nx)) rx_irq <= 1'b0;
      else if (rxi_en && (rdf_set || dr_set)) rx_irq <= 1'b1;
      if (frame_tick) rcvd_last <= push;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      err_irq <= 1'b0;
    end else if (drop) begin
      overrun <= 1'b1;
      if (rxi_en || eri_en) err_irq <= 1'b1;
    end else if (ovr_clr) begin
      overrun <= 1'b0;
      err_irq <= 1'b0;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && byte_valid && rx_enable && !overrun && !rd_req && !q_flush &&
     fill_count == CW'(DEPTH)) |=> (overrun && fill_count == CW'(DEPTH)));

  assert_full_on_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && byte_valid && rx_enable && !overrun && !rd_req && !q_flush &&
     fill_count < CW'(DEPTH) && (fill_count + 1) >= trig) |=> data_full);

  assert_gated_arrival_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && byte_valid && (!rx_enable || overrun) && !rd_req && !q_flush)
    |=> $stable(fill_count));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> (fill_count == '0 && !data_full && !data_ready && !rx_irq));

  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (data_full || data_ready));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fill_count == '0 && !frame_tick && !q_flush)
    |=> (fill_count == '0 && $stable(data_full) && $stable(data_ready)));

  assert_full_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_count == CW'(DEPTH) && rd_req && frame_tick && byte_valid && rx_enable &&
     !overrun && !q_flush && !ovr_clr) |=> (fill_count == CW'(DEPTH) && !overrun));
endmodule

// File: tb/rx_byte_queue_tb.sv
module rx_byte_queue_tb;
  logic clk = 0, rst_n = 0;
  logic q_flush = 0, rx_enable = 1, rxi_en = 1, eri_en = 1;
  logic [1:0] level_sel = 2'd1;
  logic frame_tick = 0, byte_valid = 0, rd_req = 0, rd_clr = 0, ovr_clr = 0;
  logic [7:0] byte_in = 0;
  logic [7:0] rd_data;
  logic [4:0] fill_count;
  logic data_full, data_ready, overrun, rx_irq, err_irq;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  bit ovr_m = 0;
  bit done = 0;
  byte unsigned seed = 8'h30;

  always #5 clk = ~clk;

  rx_byte_queue u_dut (
    .clk(clk), .rst_n(rst_n), .q_flush(q_flush), .rx_enable(rx_enable),
    .rxi_en(rxi_en), .eri_en(eri_en), .level_sel(level_sel),
    .frame_tick(frame_tick), .byte_valid(byte_valid), .byte_in(byte_in),
    .rd_req(rd_req), .rd_clr(rd_clr), .ovr_clr(ovr_clr), .rd_data(rd_data),
    .fill_count(fill_count), .data_full(data_full), .data_ready(data_ready),
    .overrun(overrun), .rx_irq(rx_irq), .err_irq(err_irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard (R1 ordering, R9 empty read)
  always @(negedge clk) begin
    if (rst_n && rd_req) begin
      if (exp_q.size() > 0) chk("R1 read order", rd_data, exp_q.pop_front());
      else chk("R9 empty read data", rd_data, 0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(logic [7:0] b);
    if (rx_enable && !ovr_m) begin
      if (exp_q.size() < 16) exp_q.push_back(b);
      else ovr_m = 1;
    end
    frame_tick = 1; byte_valid = 1; byte_in = b;
    step();
    frame_tick = 0; byte_valid = 0;
  endtask

  task automatic send_next();
    seed = seed + 8'd7;
    send(seed);
  endtask

  task automatic rd(bit clr);
    rd_req = 1; rd_clr = clr;
    step();
    rd_req = 0; rd_clr = 0;
  endtask

  task automatic swap(logic [7:0] b);
    exp_q.push_back(b);
    rd_req = 1; frame_tick = 1; byte_valid = 1; byte_in = b;
    step();
    rd_req = 0; frame_tick = 0; byte_valid = 0;
  endtask

  task automatic idle_tick();
    frame_tick = 1; step(); frame_tick = 0;
  endtask

  task automatic flush();
    q_flush = 1; step(); q_flush = 0;
    exp_q.delete();
  endtask

  task automatic clr_ovr();
    ovr_clr = 1; step(); ovr_clr = 0;
    ovr_m = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    chk("reset count", fill_count, 0);
    chk("reset flags", {data_full, data_ready, overrun, rx_irq, err_irq}, 0);
    chk("R9 reset rd_data", rd_data, 0);

    // trigger 4
    repeat (3) send_next();
    chk("R4 below trigger", data_full, 0);
    send_next();
    chk("R2 level 4 full", data_full, 1);
    chk("R4 rx_irq", rx_irq, 1);
    send_next();
    chk("R1 count", fill_count, 5);
    rd(1);
    chk("R8 clear held at trigger", data_full, 1);
    rd(1);
    chk("R8 clear below trigger", data_full, 0);
    chk("R8 irq drops", rx_irq, 0);

    // data-ready after two idle ticks
    idle_tick();
    chk("R5 one idle tick", data_ready, 0);
    idle_tick();
    chk("R5 two idle ticks", data_ready, 1);
    chk("R5 rx_irq", rx_irq, 1);
    rd(1);
    chk("R8 dr cleared", data_ready, 0);
    chk("R8 irq cleared", rx_irq, 0);
    rd(0); rd(0);
    chk("R1 drained", fill_count, 0);
    rd(0);
    chk("R9 empty count", fill_count, 0);
    chk("R9 empty flags", {data_full, data_ready, rx_irq}, 0);

    // trigger 14, fill and overflow
    level_sel = 2'd3;
    repeat (13) send_next();
    chk("R2 level 14 not yet", data_full, 0);
    send_next();
    chk("R2 level 14 full", data_full, 1);
    repeat (2) send_next();
    chk("R1 full count", fill_count, 16);
    send_next();
    chk("R3 overrun set", overrun, 1);
    chk("R3 err_irq", err_irq, 1);
    chk("R3 count unchanged", fill_count, 16);
    send_next();
    chk("R6 blocked by overrun", fill_count, 16);
    rd(0);
    send_next();
    chk("R6 blocked after read", fill_count, 15);
    clr_ovr();
    chk("R3 overrun cleared", overrun, 0);
    chk("R3 err_irq cleared", err_irq, 0);
    send_next();
    chk("R1 refill", fill_count, 16);
    swap(8'hA5);
    chk("R10 swap count", fill_count, 16);
    chk("R10 no overrun", overrun, 0);

    flush();
    chk("R7 count", fill_count, 0);
    chk("R7 flags", {data_full, data_ready, rx_irq}, 0);

    // overflow with interrupts disabled
    rxi_en = 0; eri_en = 0;
    repeat (17) send_next();
    chk("R3 overrun no enables", overrun, 1);
    chk("R3 err_irq masked", err_irq, 0);
    chk("R4 rx_irq masked", rx_irq, 0);
    clr_ovr();
    flush();
    chk("R7 overrun kept clear", overrun, 0);
    rxi_en = 1; eri_en = 1;

    rx_enable = 0;
    send_next();
    chk("R6 disabled receive", fill_count, 0);
    rx_enable = 1;

    level_sel = 2'd0;
    send_next();
    chk("R2 level 1 full", data_full, 1);
    flush();
    level_sel = 2'd2;
    repeat (7) send_next();
    chk("R2 level 8 not yet", data_full, 0);
    send_next();
    chk("R2 level 8 full", data_full, 1);
    repeat (8) rd(0);
    chk("R1 final drain", fill_count, 0);

    done = 1;
    finish_run();
  end
endmodule